// File: doc/BRIEF.md
# Comma Character Framer

This block sits behind a deserializer that delivers received serial bits ten at a time, with no knowledge of where the 10-bit line characters begin. It keeps the previous input word next to the current one. Across that 20-bit window it tests every one of the ten possible bit offsets for a framing character. When one is found, that offset becomes the character boundary, and every later character is cut from the stream at that boundary.

A select input chooses between two framing rules:

- **Comma rule:** only the leading eight bits must match either polarity of the comma.
- **Full rule:** all ten bits must equal the K28.5 character in either running disparity.

An enable input lets the framer hunt for a boundary. With the enable low, the boundary in use is frozen whatever bits arrive.

The outputs are all registered:

- the aligned character and its valid strobe;
- the offset in use;
- a one-cycle realignment pulse;
- a flag that the selected framing pattern was seen.

The block does no 8b/10b decoding.

Top module: `char_aligner`

## Requirements
- R1: Bit 9 of `rx_word` is the first received bit. The window is the previous word (older) followed by the current word. The candidate at offset k (0 to 9) is the ten bits starting k bits after the oldest bit of the window. All ten offsets are tested every cycle.
- R2: With `sel_k285` = 0, a candidate matches when its first eight bits are 00111110 or 11000001. The last two bits are ignored.
- R3: With `sel_k285` = 1, a candidate matches only when all ten bits are 0011111010 or 1100000101. A comma whose last two bits differ from these does not match.
- R4: When several offsets match in the same cycle, the lowest offset is taken.
- R5: On each clock, `char_o` is loaded with the ten window bits at the offset in force after that clock. Bit 9 is the first bit. A match therefore presents the framing character itself one clock after the word that completes it.
- R6: While `fr_en` is 0, `offset_o` and `char_vld` do not change, whatever bits are received.
- R7: `char_vld` stays 0 after reset until the first accepted match. From then on it stays 1 until reset.
- R8: `realign` is high for exactly the cycle after an accepted match that sets a different offset, or that is the first lock after reset.
- R9: `comma_det` is high in the cycle after any word whose window contains the selected pattern, whether or not `fr_en` is high.
- R10: A synchronous active-high `rst` clears all of the following to 0: `char_o`, `char_vld`, `realign`, `offset_o`, `comma_det` and the stored previous word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_word | input | CHAR_W | Raw received bits, bit 9 first |
| sel_k285 | input | 1 | 0: comma rule; 1: full K28.5 rule |
| fr_en | input | 1 | 1: framer may move the boundary |
| char_o | output | CHAR_W | Character at the current boundary |
| char_vld | output | 1 | Boundary established |
| realign | output | 1 | One-cycle pulse on a boundary change |
| offset_o | output | $clog2(CHAR_W) | Bit offset in use |
| comma_det | output | 1 | Selected pattern seen in the last window |

## Verification
The hardest case to reach from the ports is a window that holds two matches at different offsets in the same cycle. The only way to create it is to line up bit runs across a word edge. The bench therefore builds its stimulus as a bit queue rather than as words. It inserts a positive comma whose tail begins a negative comma five bits later, and it prefixes shift bits so that both land inside one window. The same queue places framing characters at chosen offsets across word boundaries, including a comma that fails the full rule, and a comma sent while the enable is low.

// File: rtl/char_align_pkg.sv
package char_align_pkg;
  localparam int CHAR_W = 10;
  localparam int PFX_W  = 8;
  localparam logic [PFX_W-1:0]  COMMA_POS = 8'b00111110;
  localparam logic [PFX_W-1:0]  COMMA_NEG = 8'b11000001;
  localparam logic [CHAR_W-1:0] K285_POS  = 10'b0011111010;
  localparam logic [CHAR_W-1:0] K285_NEG  = 10'b1100000101;
  typedef enum logic {SEL_COMMA = 1'b0, SEL_K285 = 1'b1} frame_sel_e;
endpackage

// File: rtl/ca_window.sv
module ca_window #(
  parameter int CHAR_W = 10
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [CHAR_W-1:0]     word_i,
  output logic [2*CHAR_W-1:0]   win_o
);
  logic [CHAR_W-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= '0;
    else     prev_q <= word_i;
  end

  // older word in the upper half: bit 2W-1 is the oldest bit
  assign win_o = {prev_q, word_i};
endmodule

// File: rtl/ca_scan.sv
module ca_scan
  import char_align_pkg::*;
#(
  parameter int CHAR_W = 10,
  parameter int N_OFF  = CHAR_W
) (
  input  logic [2*CHAR_W-1:0] win_i,
  input  logic                full_k_i,
  output logic [N_OFF-1:0]    hit_o
);
  for (genvar g = 0; g < N_OFF; g++) begin : g_off
    logic [CHAR_W-1:0] cand;
    logic              pfx_hit;
    logic              full_hit;
    assign cand     = win_i[2*CHAR_W-1-g -: CHAR_W];
    assign pfx_hit  = (cand[CHAR_W-1 -: PFX_W] == COMMA_POS) ||
                      (cand[CHAR_W-1 -: PFX_W] == COMMA_NEG);
    assign full_hit = (cand == K285_POS) || (cand == K285_NEG);
    assign hit_o[g] = full_k_i ? full_hit : pfx_hit;
  end
endmodule

// File: rtl/ca_pick.sv
module ca_pick #(
  parameter int N_OFF = 10,
  parameter int OFF_W = $clog2(N_OFF)
) (
  input  logic [N_OFF-1:0] hit_i,
  output logic             any_o,
  output logic [OFF_W-1:0] idx_o
);
  always_comb begin
    idx_o = '0;
    for (int i = N_OFF - 1; i >= 0; i--) begin
      if (hit_i[i]) idx_o = OFF_W'(i);
    end
  end
  assign any_o = |hit_i;
endmodule

// File: rtl/char_aligner.sv
module char_aligner
  import char_align_pkg::*;
#(
  parameter int CHAR_W = 10
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [CHAR_W-1:0]         rx_word,
  input  logic                      sel_k285,
  input  logic                      fr_en,
  output logic [CHAR_W-1:0]         char_o,
  output logic                      char_vld,
  output logic                      realign,
  output logic [$clog2(CHAR_W)-1:0] offset_o,
  output logic                      comma_det
);
  localparam int OFF_W = $clog2(CHAR_W);
  localparam int WIN_W = 2 * CHAR_W;

  logic [WIN_W-1:0]  win;
  logic [CHAR_W-1:0] hit_vec;
  logic              hit_any;
  logic [OFF_W-1:0]  hit_idx;
  logic              take;
  logic [OFF_W-1:0]  nxt_off;
  logic [WIN_W-1:0]  shifted;
  frame_sel_e        sel_mode;

  assign sel_mode = sel_k285 ? SEL_K285 : SEL_COMMA;

  ca_window #(.CHAR_W(CHAR_W)) u_win (
    .clk(clk), .rst(rst), .word_i(rx_word), .win_o(win)
  );

  ca_scan #(.CHAR_W(CHAR_W), .N_OFF(CHAR_W)) u_scan (
    .win_i(win), .full_k_i(sel_mode == SEL_K285), .hit_o(hit_vec)
  );

  ca_pick #(.N_OFF(CHAR_W), .OFF_W(OFF_W)) u_pick (
    .hit_i(hit_vec), .any_o(hit_any), .idx_o(hit_idx)
  );

  assign take    = fr_en && hit_any;
  assign nxt_off = take ? hit_idx : offset_o;
  assign shifted = win << nxt_off;

  always_ff @(posedge clk) begin
    if (rst) begin
      offset_o  <= '0;
      char_vld  <= 1'b0;
      realign   <= 1'b0;
      char_o    <= '0;
      comma_det <= 1'b0;
    end else begin
      offset_o  <= nxt_off;
      char_vld  <= char_vld | take;
      realign   <= take && (!char_vld || (hit_idx != offset_o));
      char_o    <= shifted[WIN_W-1 -: CHAR_W];
      comma_det <= hit_any;
    end
  end
endmodule

// File: rtl/char_aligner_chk.sv
module char_aligner_chk #(
  parameter int CHAR_W = 10
) (
  input logic                      clk,
  input logic                      rst,
  input logic                      fr_en,
  input logic                      char_vld,
  input logic                      realign,
  input logic [$clog2(CHAR_W)-1:0] offset_o,
  input logic                      comma_det
);
  p_vld_sticky_r7: assert property (@(posedge clk) disable iff (rst)
    char_vld |=> char_vld);

  p_frozen_off_r6: assert property (@(posedge clk) disable iff (rst)
    !fr_en |=> $stable(offset_o));

  p_frozen_vld_r6: assert property (@(posedge clk) disable iff (rst)
    !fr_en |=> $stable(char_vld));

  p_realign_vld_r8: assert property (@(posedge clk) disable iff (rst)
    realign |-> char_vld);

  p_realign_on_move_r8: assert property (@(posedge clk) disable iff (rst)
    (offset_o != $past(offset_o)) |-> realign);

  p_realign_seen_r9: assert property (@(posedge clk) disable iff (rst)
    realign |-> comma_det);

  p_off_range_r1: assert property (@(posedge clk) disable iff (rst)
    int'(offset_o) < CHAR_W);
endmodule

bind char_aligner char_aligner_chk #(.CHAR_W(CHAR_W)) u_chk (
  .clk(clk), .rst(rst), .fr_en(fr_en), .char_vld(char_vld),
  .realign(realign), .offset_o(offset_o), .comma_det(comma_det)
);

// File: tb/char_aligner_test.sv
module char_aligner_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [9:0] rx_word = '0;
  logic       sel_k285 = 1'b0;
  logic       fr_en = 1'b1;
  logic [9:0] char_o;
  logic       char_vld, realign, comma_det;
  logic [3:0] offset_o;

  int n_cmp = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  char_aligner uut (
    .clk(clk), .rst(rst), .rx_word(rx_word), .sel_k285(sel_k285),
    .fr_en(fr_en), .char_o(char_o), .char_vld(char_vld),
    .realign(realign), .offset_o(offset_o), .comma_det(comma_det)
  );

  // reference model state
  bit m_prev [10];
  int m_off;
  bit m_lock;
  int e_char, e_off;
  bit e_vld, e_re, e_det;
  bit bitq[$];
  int unsigned rng = 32'h1234_5678;

  function automatic bit cand_match(bit w[20], int k, bit full);
    int v = 0;
    for (int j = 0; j < 10; j++) v = v * 2 + w[k + j];
    if (full) return (v == 'b0011111010) || (v == 'b1100000101);
    return ((v >> 2) == 'b00111110) || ((v >> 2) == 'b11000001);
  endfunction

  task automatic model_reset();
    for (int i = 0; i < 10; i++) m_prev[i] = 0;
    m_off = 0; m_lock = 0;
    e_char = 0; e_off = 0; e_vld = 0; e_re = 0; e_det = 0;
  endtask

  task automatic model_eval(logic [9:0] w);
    bit win[20];
    int first = -1;
    int use_off;
    bit tk;
    for (int i = 0; i < 10; i++) begin
      win[i] = m_prev[i];
      win[10 + i] = w[9 - i];
    end
    for (int k = 9; k >= 0; k--)
      if (cand_match(win, k, sel_k285)) first = k;
    tk = fr_en && (first >= 0);
    use_off = tk ? first : m_off;
    e_re  = tk && (!m_lock || first != m_off);
    e_det = (first >= 0);
    if (tk) m_lock = 1;
    m_off = use_off;
    e_vld = m_lock;
    e_off = m_off;
    e_char = 0;
    for (int j = 0; j < 10; j++) e_char = e_char * 2 + win[use_off + j];
    for (int i = 0; i < 10; i++) m_prev[i] = w[9 - i];
  endtask

  task automatic chk(string tag, string what, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic compare_all(string tag);
    chk(tag, "char_o", int'(char_o), e_char);
    chk(tag, "char_vld", int'(char_vld), int'(e_vld));
    chk(tag, "realign", int'(realign), int'(e_re));
    chk(tag, "offset_o", int'(offset_o), e_off);
    chk(tag, "comma_det", int'(comma_det), int'(e_det));
  endtask

  task automatic step(logic [9:0] w, string tag);
    rx_word = w;
    model_eval(w);
    @(posedge clk);
    @(negedge clk);
    compare_all(tag);
  endtask

  task automatic push_bits(int val, int n);
    for (int i = n - 1; i >= 0; i--) bitq.push_back(bit'((val >> i) & 1));
  endtask

  task automatic drain(string tag);
    while (bitq.size() >= 10) begin
      logic [9:0] w;
      for (int i = 9; i >= 0; i--) w[i] = bitq.pop_front();
      step(w, tag);
    end
  endtask

  task automatic filler(int n);
    for (int i = 0; i < n; i++) push_bits('b0101010101, 10);
  endtask

  task automatic do_reset(string tag);
    @(negedge clk);
    rst = 1'b1;
    bitq.delete();
    repeat (3) @(posedge clk);
    @(negedge clk);
    model_reset();
    compare_all(tag);
    rst = 1'b0;
  endtask

  initial begin
    // R10: reset values
    do_reset("R10");
    // R7: no framing character yet, valid stays low
    filler(6); drain("R7");

    // R1 R2 R5 R8: comma rule, K28.5+ at offset 3 across a word edge
    sel_k285 = 1'b0;
    push_bits(0, 3); push_bits('b0011111010, 10); filler(5); drain("R2");
    // R5: following characters cut at the locked offset
    for (int i = 0; i < 8; i++) push_bits(i * 37 + 5, 10);
    drain("R5");
    // R8: shift boundary by 4 bits, send negative comma with odd tail
    push_bits('b1010, 4); push_bits('b1100000110, 10); filler(4); drain("R8");

    // R6 R9: framer disabled, comma at a new offset must not move boundary
    fr_en = 1'b0;
    push_bits('b01, 2); push_bits('b0011111010, 10); filler(4); drain("R6");
    push_bits('b1, 1); push_bits('b1100000101, 10); filler(3); drain("R9");
    fr_en = 1'b1;

    // R3: full rule rejects a comma with wrong tail, then accepts K28.5-
    sel_k285 = 1'b1;
    push_bits('b110, 3); push_bits('b0011111001, 10); filler(4); drain("R3");
    push_bits('b01011, 5); push_bits('b1100000101, 10); filler(4); drain("R3");

    // R4: positive comma with a negative comma five bits later, same window
    sel_k285 = 1'b0;
    push_bits('b01, 2); push_bits('b0011111000001, 13); push_bits('b10101, 5);
    filler(4); drain("R4");
    push_bits('b0, 1); push_bits('b0011111000001, 13); push_bits('b0101, 4);
    filler(4); drain("R4");

    // R1 R2 R3 R8 R9: pseudo-random traffic in both rules, enable toggling
    for (int i = 0; i < 400; i++) begin
      rng ^= rng << 13; rng ^= rng >> 17; rng ^= rng << 5;
      sel_k285 = (i >= 200);
      fr_en = (rng[31:28] != 4'h0);
      if (rng[27:24] == 4'h3) begin
        push_bits(int'(rng[3:0] % 10), int'(rng[7:4] % 7));
        push_bits(rng[8] ? 'b0011111010 : 'b1100000101, 10);
      end else begin
        push_bits(int'(rng[9:0]), 10);
      end
      drain("R1");
    end
    fr_en = 1'b1;

    // R10 R7: mid-stream reset drops lock
    do_reset("R10");
    filler(3); drain("R7");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule